// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block is the master side of a control-register port on a PHY. The port moves 16-bit values in a four-phase request/acknowledge exchange. A host asks for a register write or a register read through a ready/valid request. The block then splits the request into a chain of port commands. Each command puts a value on the port data field and raises one strobe. The block waits for the PHY to raise acknowledge, drops the strobe while holding the value, and waits for acknowledge to fall again.

Each acknowledge wait is bounded by a timer built from a clock prescaler and a count of polling ticks. If a wait runs past its bound, the chain stops and the block reports which half of the handshake stalled. When the configuration input is set out of reset, the block first runs a fixed tuning sequence of two register writes. These writes set the loss-of-signal detector threshold and raise the transmit boost level.

Top module: `crport_master`

## Requirements
- R1: In the cycle after reset is released, `reqReady` is low. No strobe, `doneValid` or `errTimeout` is high. With `tuneEn` low at that first clock, no strobe rises, and from the second cycle on `reqReady` is high.
- R2: Only one strobe is high at a time. The strobe and `portDin` change together. The strobe stays high until `portAck` is seen high and then falls. The next command starts only after `portAck` is seen low again.
- R3: A write request (`reqWrite`=1) runs three commands in order: capture-address with `reqAddr`, capture-data with `reqData`, then the write strobe with `reqData`.
- R4: A read request (`reqWrite`=0) runs capture-address with `reqAddr`, then the read strobe. `portDout` is captured in the cycle where `portAck` is seen high during the read strobe, and it stays on `rdData` from then on.
- R5: If `portAck` has not been seen high within PRESCALE*POLL_LIMIT cycles of a strobe rising, the chain aborts. `errTimeout` becomes 1 and `errPhase` becomes 0. An acknowledge seen in the last cycle of the window still counts.
- R6: If `portAck` has not been seen low within PRESCALE*POLL_LIMIT cycles of a strobe falling, the chain aborts with `errTimeout`=1 and `errPhase`=1.
- R7: An abort drops every strobe, skips the rest of the chain and returns to ready. `errTimeout` then stays high until the next request is accepted, which clears it.
- R8: A request is taken only on a clock where `reqValid` and `reqReady` are both high. `reqReady` is high only while no chain is running. Each host request ends with exactly one one-cycle `doneValid` pulse, whether it completes or aborts.
- R9: With `tuneEn` high at the first clock after reset, the block writes 16'hA409 to address 16'h0015 and then 16'hA000 to address 16'h0012. `reqReady` stays low and `doneValid` stays low throughout this sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tuneEn | input | 1 | Run the tuning writes after reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqAddr | input | DATA_W | Register address |
| reqData | input | DATA_W | Write value |
| doneValid | output | 1 | One-cycle pulse when a host request ends |
| rdData | output | DATA_W | Last value read from the port |
| errTimeout | output | 1 | Sticky acknowledge timeout flag |
| errPhase | output | 1 | 0 = stalled waiting for ack high, 1 = for ack low |
| portDin | output | DATA_W | Value driven to the port |
| portCapAddr | output | 1 | Capture-address strobe |
| portCapData | output | 1 | Capture-data strobe |
| portRd | output | 1 | Read strobe |
| portWr | output | 1 | Write strobe |
| portAck | input | 1 | Port acknowledge |
| portDout | input | DATA_W | Value returned by the port |

## Verification
The bench builds the block with PRESCALE=3 and POLL_LIMIT=5, which gives a 15-cycle acknowledge window. At that size a behavioural PHY responder with adjustable rise and fall delays can place an acknowledge in the last cycle of the window, and one cycle beyond it, for both halves of the handshake. The tuning sequence and the host traffic are both run against a model that tracks the command queue cycle by cycle.

// File: rtl/crport_pkg.sv
package crport_pkg;

  typedef enum logic [1:0] {
    CMD_CAPADDR,
    CMD_CAPDATA,
    CMD_WRITE,
    CMD_READ
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHost;  // take address/data from the host request
    logic loadTune;  // take address/data from the tuning table
    logic tuneSel;   // which tuning write (0 first, 1 second)
    logic selData;   // drive data register instead of address register
    logic clrTimer;  // restart the acknowledge timer
    logic capRead;   // capture port read data
  } dpCtl_t;

  // tuning writes: LOS bias 5, override enable, level 9; then tx boost 5
  localparam logic [15:0] TUNE_ADDR0 = 16'h0015;
  localparam logic [15:0] TUNE_DATA0 = (16'd5 << 13) | (16'd1 << 10) | 16'd9;
  localparam logic [15:0] TUNE_ADDR1 = 16'h0012;
  localparam logic [15:0] TUNE_DATA1 = 16'd5 << 13;

endpackage

// File: rtl/crport_dp.sv
module crport_dp
  import crport_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PRESCALE   = 200,
  parameter int POLL_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] portDout,
  output logic [DATA_W-1:0] portDin,
  output logic [DATA_W-1:0] rdData,
  output logic              timeout
);

  localparam int PRE_W  = $clog2(PRESCALE + 1);
  localparam int TICK_W = $clog2(POLL_LIMIT + 1);

  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [DATA_W-1:0] addrReg, dataReg;

  // polling interval prescaler and tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.clrTimer) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (preCnt == PRE_W'(PRESCALE - 1)) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign timeout = (preCnt == PRE_W'(PRESCALE - 1)) &&
                   (tickCnt == TICK_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (ctl.loadHost) begin
      addrReg <= reqAddr;
      dataReg <= reqData;
    end else if (ctl.loadTune) begin
      addrReg <= ctl.tuneSel ? DATA_W'(TUNE_ADDR1) : DATA_W'(TUNE_ADDR0);
      dataReg <= ctl.tuneSel ? DATA_W'(TUNE_DATA1) : DATA_W'(TUNE_DATA0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capRead) rdData <= portDout;
  end

  assign portDin = ctl.selData ? dataReg : addrReg;

  // R2
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadHost || ctl.loadTune) |=> $stable(addrReg) && $stable(dataReg));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capRead |=> $stable(rdData));

endmodule

// File: rtl/crport_ctrl.sv
module crport_ctrl
  import crport_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tuneEn,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   portAck,
  input  logic   timeout,
  output logic   reqReady,
  output logic   doneValid,
  output logic   errTimeout,
  output logic   errPhase,
  output logic   portCapAddr,
  output logic   portCapData,
  output logic   portRd,
  output logic   portWr,
  output dpCtl_t ctl
);

  typedef enum logic [1:0] {S_BOOT, S_IDLE, S_RISE, S_FALL} state_e;

  state_e   state, stateN;
  logic [1:0] step, stepN;
  logic     isRead, isReadN, isHost, isHostN, tuneIdx, tuneIdxN;
  logic     doneN, errN, phaseN;
  cmdKind_e kind;
  logic [1:0] lastStep;
  logic     anyStrobe;

  always_comb begin
    if (step == 2'd0)      kind = CMD_CAPADDR;
    else if (isRead)       kind = CMD_READ;
    else if (step == 2'd1) kind = CMD_CAPDATA;
    else                   kind = CMD_WRITE;
  end

  assign lastStep = isRead ? 2'd1 : 2'd2;

  always_comb begin
    stateN   = state;
    stepN    = step;
    isReadN  = isRead;
    isHostN  = isHost;
    tuneIdxN = tuneIdx;
    doneN    = 1'b0;
    errN     = errTimeout;
    phaseN   = errPhase;
    ctl      = '0;
    ctl.selData = (kind != CMD_CAPADDR);
    case (state)
      S_BOOT: begin
        if (tuneEn) begin
          ctl.loadTune = 1'b1;
          stateN   = S_RISE;
          stepN    = 2'd0;
          isReadN  = 1'b0;
          isHostN  = 1'b0;
          tuneIdxN = 1'b0;
        end else begin
          stateN = S_IDLE;
        end
      end
      S_IDLE: begin
        if (reqValid) begin
          ctl.loadHost = 1'b1;
          stateN  = S_RISE;
          stepN   = 2'd0;
          isReadN = !reqWrite;
          isHostN = 1'b1;
          errN    = 1'b0;
        end
      end
      S_RISE: begin
        if (portAck) begin
          ctl.capRead = (kind == CMD_READ);
          stateN = S_FALL;
        end else if (timeout) begin
          stateN = S_IDLE;
          errN   = 1'b1;
          phaseN = 1'b0;
          doneN  = isHost;
        end
      end
      S_FALL: begin
        if (!portAck) begin
          if (step != lastStep) begin
            stepN  = step + 2'd1;
            stateN = S_RISE;
          end else if (!isHost && !tuneIdx) begin
            ctl.loadTune = 1'b1;
            ctl.tuneSel  = 1'b1;
            tuneIdxN = 1'b1;
            stepN    = 2'd0;
            stateN   = S_RISE;
          end else begin
            stateN = S_IDLE;
            doneN  = isHost;
          end
        end else if (timeout) begin
          stateN = S_IDLE;
          errN   = 1'b1;
          phaseN = 1'b1;
          doneN  = isHost;
        end
      end
      default: stateN = S_IDLE;
    endcase
    ctl.clrTimer = (stateN != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_BOOT;
      step       <= '0;
      isRead     <= 1'b0;
      isHost     <= 1'b0;
      tuneIdx    <= 1'b0;
      doneValid  <= 1'b0;
      errTimeout <= 1'b0;
      errPhase   <= 1'b0;
    end else begin
      state      <= stateN;
      step       <= stepN;
      isRead     <= isReadN;
      isHost     <= isHostN;
      tuneIdx    <= tuneIdxN;
      doneValid  <= doneN;
      errTimeout <= errN;
      errPhase   <= phaseN;
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign portCapAddr = (state == S_RISE) && (kind == CMD_CAPADDR);
  assign portCapData = (state == S_RISE) && (kind == CMD_CAPDATA);
  assign portRd      = (state == S_RISE) && (kind == CMD_READ);
  assign portWr      = (state == S_RISE) && (kind == CMD_WRITE);
  assign anyStrobe   = portCapAddr | portCapData | portRd | portWr;

  // R2
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({portCapAddr, portCapData, portRd, portWr}));

  // R2
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> $past(portAck) || errTimeout);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !anyStrobe);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !errTimeout);

endmodule

// File: rtl/crport_master.sv
module crport_master
  import crport_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PRESCALE   = 200,
  parameter int POLL_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tuneEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic              errTimeout,
  output logic              errPhase,
  output logic [DATA_W-1:0] portDin,
  output logic              portCapAddr,
  output logic              portCapData,
  output logic              portRd,
  output logic              portWr,
  input  logic              portAck,
  input  logic [DATA_W-1:0] portDout
);

  dpCtl_t ctl;
  logic   timeout;

  crport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tuneEn(tuneEn),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .portAck(portAck), .timeout(timeout),
    .reqReady(reqReady), .doneValid(doneValid),
    .errTimeout(errTimeout), .errPhase(errPhase),
    .portCapAddr(portCapAddr), .portCapData(portCapData),
    .portRd(portRd), .portWr(portWr), .ctl(ctl)
  );

  crport_dp #(
    .DATA_W(DATA_W), .PRESCALE(PRESCALE), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqData(reqData), .portDout(portDout),
    .portDin(portDin), .rdData(rdData), .timeout(timeout)
  );

endmodule

// File: tb/crport_master_bench.sv
`timescale 1ns/1ps
module crport_master_bench;
  localparam int W    = 16;
  localparam int PRE  = 3;
  localparam int POLL = 5;
  localparam int LIM  = PRE * POLL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tuneEn = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [W-1:0] reqAddr = '0, reqData = '0;
  logic reqReady, doneValid, errTimeout, errPhase;
  logic [W-1:0] rdData, portDin, portDout;
  logic portCapAddr, portCapData, portRd, portWr, portAck;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  crport_master #(.DATA_W(W), .PRESCALE(PRE), .POLL_LIMIT(POLL)) u_crport_master (
    .clk(clk), .rstN(rstN), .tuneEn(tuneEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .doneValid(doneValid),
    .rdData(rdData), .errTimeout(errTimeout), .errPhase(errPhase),
    .portDin(portDin), .portCapAddr(portCapAddr), .portCapData(portCapData),
    .portRd(portRd), .portWr(portWr), .portAck(portAck), .portDout(portDout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural PHY responder ----------------
  int riseDelay = 1, fallDelay = 1, rc = 0, fc = 0;
  logic [W-1:0] rAddr = '0, rData = '0;
  logic [W-1:0] mem [64];
  wire anyStb = portCapAddr | portCapData | portRd | portWr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portAck  <= 1'b0;
      portDout <= '0;
      rc = 0; fc = 0;
    end else if (anyStb && !portAck) begin
      fc = 0;
      if (rc >= riseDelay) begin
        rc = 0;
        portAck <= 1'b1;
        if (portCapAddr) rAddr = portDin;
        if (portCapData) rData = portDin;
        if (portWr) mem[rAddr[5:0]] = rData;
        if (portRd) portDout <= mem[rAddr[5:0]];
      end else rc++;
    end else if (!anyStb && portAck) begin
      rc = 0;
      if (fc >= fallDelay) begin
        fc = 0;
        portAck <= 1'b0;
      end else fc++;
    end else begin
      rc = 0; fc = 0;
    end
  end

  // ---------------- reference model ----------------
  typedef struct { int kind; logic [W-1:0] val; } cmd_t;  // 1 capA 2 capD 3 wr 4 rd
  cmd_t q[$];
  bit mBoot, mActive, mHigh, mHost, mDone, mErr;
  int mPhase, mWait;
  logic [W-1:0] mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      mBoot = 1; mActive = 0; mHigh = 0; mHost = 0; mDone = 0; mErr = 0;
      mPhase = 0; mWait = 0; mRd = '0;
    end else begin
      mDone = 0;
      if (mBoot) begin
        mBoot = 0;
        if (tuneEn) begin
          q.push_back('{1, 16'h0015}); q.push_back('{2, 16'hA409}); q.push_back('{3, 16'hA409});
          q.push_back('{1, 16'h0012}); q.push_back('{2, 16'hA000}); q.push_back('{3, 16'hA000});
          mActive = 1; mHigh = 1; mWait = 0; mHost = 0;
        end
      end else if (mActive) begin
        if (mHigh) begin
          if (portAck) begin
            if (q[0].kind == 4) mRd = portDout;
            mHigh = 0; mWait = 0;
          end else if (mWait == LIM - 1) begin
            q.delete(); mActive = 0; mErr = 1; mPhase = 0; mDone = mHost;
          end else mWait++;
        end else begin
          if (!portAck) begin
            void'(q.pop_front());
            mWait = 0;
            if (q.size() == 0) begin mActive = 0; mDone = mHost; end
            else mHigh = 1;
          end else if (mWait == LIM - 1) begin
            q.delete(); mActive = 0; mErr = 1; mPhase = 1; mDone = mHost;
          end else mWait++;
        end
      end else if (reqValid) begin
        mErr = 0;
        q.push_back('{1, reqAddr});
        if (reqWrite) begin q.push_back('{2, reqData}); q.push_back('{3, reqData}); end
        else q.push_back('{4, reqData});
        mActive = 1; mHigh = 1; mWait = 0; mHost = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] expStb;
      expStb = 4'b0;
      if (mActive && mHigh)
        case (q[0].kind)
          1: expStb = 4'b1000;
          2: expStb = 4'b0100;
          3: expStb = 4'b0001;
          default: expStb = 4'b0010;
        endcase
      chk({portCapAddr, portCapData, portRd, portWr} == expStb, "R2 strobes",
          {28'd0, portCapAddr, portCapData, portRd, portWr}, {28'd0, expStb});
      if (mActive && q[0].kind != 4)
        chk(portDin == q[0].val, "R3 portDin", portDin, q[0].val);
      chk(reqReady == (!mBoot && !mActive), "R8 reqReady", reqReady, !mBoot && !mActive);
      chk(doneValid == mDone, "R8 doneValid", doneValid, mDone);
      chk(rdData == mRd, "R4 rdData", rdData, mRd);
      chk(errTimeout == mErr, "R5 errTimeout", errTimeout, mErr);
      if (mErr) chk(errPhase == mPhase[0], "R6 errPhase", errPhase, mPhase);
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input bit wr, input logic [W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 0;
    while (!doneValid) @(negedge clk);
  endtask

  task automatic doReset(input bit te);
    @(negedge clk);
    rstN = 0; tuneEn = te;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;

    // R9 tuning sequence
    doReset(1'b1);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    chk(mem[6'h15] == 16'hA409, "R9 tune write 0x15", mem[6'h15], 16'hA409);
    chk(mem[6'h12] == 16'hA000, "R9 tune write 0x12", mem[6'h12], 16'hA000);

    // R1 reset with tuning off
    mem[6'h15] = '0; mem[6'h12] = '0;
    doReset(1'b0);
    #1;
    chk(!reqReady && !doneValid && !errTimeout, "R1 first cycle idle",
        {reqReady, doneValid, errTimeout}, 0);
    chk(!anyStb, "R1 no strobe", anyStb, 0);
    repeat (20) @(negedge clk);
    chk(reqReady, "R1 ready", reqReady, 1);
    chk(mem[6'h15] == 0 && mem[6'h12] == 0, "R1 no tune traffic", mem[6'h15], 0);

    // R3 / R4 normal traffic with varied delays
    riseDelay = 1; fallDelay = 1;
    doReq(1'b1, 16'h0007, 16'h1234);
    chk(mem[7] == 16'h1234, "R3 write 0x07", mem[7], 16'h1234);
    riseDelay = 0; fallDelay = 3;
    doReq(1'b1, 16'h003F, 16'hBEEF);
    chk(mem[63] == 16'hBEEF, "R3 write 0x3F", mem[63], 16'hBEEF);
    riseDelay = 4; fallDelay = 0;
    doReq(1'b0, 16'h0007, 16'h0000);
    @(negedge clk);
    chk(rdData == 16'h1234, "R4 read 0x07", rdData, 16'h1234);
    doReq(1'b0, 16'h003F, 16'h0000);
    @(negedge clk);
    chk(rdData == 16'hBEEF, "R4 read 0x3F", rdData, 16'hBEEF);

    // R5 boundary: ack in the last cycle of the window
    riseDelay = LIM - 2; fallDelay = 1;
    doReq(1'b1, 16'h0008, 16'h7777);
    chk(!errTimeout && mem[8] == 16'h7777, "R5 last-cycle ack ok", mem[8], 16'h7777);

    // R5 one cycle beyond: rise timeout
    riseDelay = LIM - 1;
    doReq(1'b1, 16'h0009, 16'h5555);
    @(negedge clk);
    chk(errTimeout && !errPhase, "R5 rise timeout", {errTimeout, errPhase}, 2'b10);
    chk(mem[9] == 0, "R7 chain aborted", mem[9], 0);
    chk(reqReady && !anyStb, "R7 idle after abort", {reqReady, anyStb}, 2'b10);

    // R6 fall timeout
    riseDelay = 1; fallDelay = LIM - 1;
    doReq(1'b1, 16'h000A, 16'h4444);
    @(negedge clk);
    chk(errTimeout && errPhase, "R6 fall timeout", {errTimeout, errPhase}, 2'b11);
    chk(mem[10] == 0, "R6 chain aborted", mem[10], 0);
    fallDelay = 1;
    repeat (LIM) @(negedge clk);
    chk(errTimeout, "R7 error sticky", errTimeout, 1);

    // R7 next request clears the error
    doReq(1'b1, 16'h000B, 16'h2222);
    chk(!errTimeout && mem[11] == 16'h2222, "R7 cleared by request", errTimeout, 0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule